// File: doc/BRIEF.md
# Request/Acknowledge Handshake Controller

This block pairs a sender-side state machine and a receiver-side state machine, joined only by a request line and an acknowledge line. A single start pulse on the sender side launches one transfer of a data word. The receiver raises acknowledge once it sees request and its own ready input allows it, and it captures the word at that moment. The sender reports the end of a transfer with a one-cycle done pulse.

A two-bit mode input chooses one of three withdrawal disciplines. In the loose discipline, each side drops its line after its own programmed hold time and ignores the other side. In the half-locked discipline, the sender waits for acknowledge before dropping request, but the receiver still drops acknowledge on a timer. In the fully locked discipline, each line falls only after the opposite line has been seen to move. Two separate hold counts, each from 1 to 255 cycles, set the timed withdrawals. A watchdog stops a sender that never receives an answer.

Top module: `req_ack_handshake`

## Requirements
- R1: While reset is applied, req_o, ack_o, done_o, timeout_o and rdata_valid_o are all low.
- R2: mode_i encoding: 0 selects loose, 1 selects half-locked, and 2 or 3 select fully locked. In loose mode, req_o stays high for exactly snd_hold_i cycles, whatever ack_o does.
- R3: In loose and half-locked modes, ack_o stays high for exactly rcv_hold_i cycles, whatever req_o does. The receiver does not answer the same request a second time before req_o has been low.
- R4: In half-locked and fully locked modes, req_o falls in the cycle after the first cycle in which ack_o is high.
- R5: In fully locked mode, ack_o falls in the cycle after the first cycle in which req_o is low.
- R6: ack_o rises only in the cycle after a cycle in which req_o and ready_i were both high.
- R7: The receiver latches the sender's word into rdata_o on the cycle ack_o rises and pulses rdata_valid_o once. The sender takes its word from wdata_i at the accepted start and holds it while req_o is high, so later changes on wdata_i do not matter.
- R8: A start_i pulse is ignored while a transfer is in progress or while ack_o is still high, and it launches no second request.
- R9: For a completed transfer, done_o is high for exactly one cycle, which is the first cycle in which req_o is low again.
- R10: In half-locked or fully locked mode, if no acknowledge arrives within TO_CYC (1024) cycles of request, req_o drops after 1024 high cycles and timeout_o goes high with no done pulse. timeout_o stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Withdrawal discipline (0 loose, 1 half-locked, 2/3 fully locked) |
| snd_hold_i | input | HW | Sender request hold count in loose mode |
| rcv_hold_i | input | HW | Receiver acknowledge hold count in loose/half-locked modes |
| start_i | input | 1 | Start pulse for a transfer |
| wdata_i | input | DW | Word to send |
| ready_i | input | 1 | Receiver may acknowledge |
| req_o | output | 1 | Request line |
| ack_o | output | 1 | Acknowledge line |
| rdata_o | output | DW | Word captured by the receiver |
| rdata_valid_o | output | 1 | One-cycle pulse when rdata_o is updated |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Watchdog expiry flag |

## Verification
The hardest cases to reach are those where the two timers disagree. Examples are a loose-mode request that ends before the receiver becomes ready, or an acknowledge that outlives its request while a new start arrives. The bench sweeps every mode against several sender holds, receiver holds and ready delays. It computes each line's high time from the formulas in the requirements. It places extra start pulses at chosen cycles: in the middle of a request, and in the window after request falls while acknowledge is still high. It holds ready low for over a thousand cycles to drive the watchdog to expiry.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_LOOSE  = 2'd0,
    HS_HALF   = 2'd1,
    HS_FULL   = 2'd2,
    HS_FULL_B = 2'd3
  } hs_mode_e;

  // sender drops request on its own timer
  function automatic logic snd_timed(input logic [1:0] m);
    return m == HS_LOOSE;
  endfunction

  // receiver drops acknowledge on its own timer
  function automatic logic rcv_timed(input logic [1:0] m);
    return m[1] == 1'b0;
  endfunction
endpackage

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int DW     = 16,
  parameter int HW     = 8,
  parameter int TO_CYC = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [HW-1:0] hold_i,
  input  logic          start_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [DW-1:0] data_o,
  output logic          done_o,
  output logic          timeout_o
);
  localparam int CW = $clog2(TO_CYC + 1);

  typedef enum logic {M_IDLE, M_REQ} m_st_e;

  m_st_e         st_q;
  logic [CW-1:0] cnt_q;
  logic          req_q, done_q, to_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] hold_w, lim_w;
  logic          timed_w;

  assign hold_w  = (hold_i == '0) ? CW'(1) : CW'(hold_i);
  assign lim_w   = CW'(TO_CYC);
  assign timed_w = snd_timed(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      cnt_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        M_IDLE: begin
          if (start_i && !ack_i) begin
            req_q  <= 1'b1;
            data_q <= wdata_i;
            cnt_q  <= CW'(1);
            to_q   <= 1'b0;
            st_q   <= M_REQ;
          end
        end
        M_REQ: begin
          if (timed_w) begin
            if (cnt_q >= hold_w) begin
              req_q  <= 1'b0;
              done_q <= 1'b1;
              st_q   <= M_IDLE;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end else if (ack_i) begin
            req_q  <= 1'b0;
            done_q <= 1'b1;
            st_q   <= M_IDLE;
          end else if (cnt_q >= lim_w) begin
            req_q <= 1'b0;
            to_q  <= 1'b1;
            st_q  <= M_IDLE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign req_o     = req_q;
  assign data_o    = data_q;
  assign done_o    = done_q;
  assign timeout_o = to_q;

  // R4
  req_drop_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(req_q) && !snd_timed(mode_i) && !$rose(to_q)) |-> $past(ack_i));
  // R7
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && $past(req_q)) |-> $stable(data_q));
  // R8
  req_rise_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(start_i && !ack_i));
  // R9
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!req_q && $past(req_q)));
  // R10
  timeout_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> (!req_q && $past(req_q) && !done_q));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [HW-1:0] hold_i,
  input  logic          req_i,
  input  logic          ready_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  typedef enum logic [1:0] {S_IDLE, S_ACK, S_REARM} s_st_e;

  s_st_e         st_q;
  logic [HW-1:0] cnt_q, hold_w;
  logic          ack_q, rv_q;
  logic [DW-1:0] rdata_q;

  assign hold_w = (hold_i == '0) ? HW'(1) : hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      rv_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      rv_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (req_i && ready_i) begin
            ack_q   <= 1'b1;
            rdata_q <= data_i;
            rv_q    <= 1'b1;
            cnt_q   <= HW'(1);
            st_q    <= S_ACK;
          end
        end
        S_ACK: begin
          if (rcv_timed(mode_i)) begin
            if (cnt_q >= hold_w) begin
              ack_q <= 1'b0;
              st_q  <= S_REARM;
            end else begin
              cnt_q <= cnt_q + HW'(1);
            end
          end else if (!req_i) begin
            ack_q <= 1'b0;
            st_q  <= S_IDLE;
          end
        end
        S_REARM: if (!req_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ack_o    = ack_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rv_q;

  // R6
  ack_rise_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_i && ready_i));
  // R5
  full_ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ack_q) && !rcv_timed(mode_i)) |-> $past(!req_i));
  // R7
  capture_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv_q |-> ($rose(ack_q) && rdata_q == $past(data_i)));
endmodule

// File: rtl/req_ack_handshake.sv
module req_ack_handshake #(
  parameter int DW     = 16,
  parameter int HW     = 8,
  parameter int TO_CYC = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [HW-1:0] snd_hold_i,
  input  logic [HW-1:0] rcv_hold_i,
  input  logic          start_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ready_i,
  output logic          req_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_valid_o,
  output logic          done_o,
  output logic          timeout_o
);
  logic          req_w, ack_w;
  logic [DW-1:0] bus_w;

  hs_master #(.DW(DW), .HW(HW), .TO_CYC(TO_CYC)) u_master (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .hold_i    (snd_hold_i),
    .start_i   (start_i),
    .wdata_i   (wdata_i),
    .ack_i     (ack_w),
    .req_o     (req_w),
    .data_o    (bus_w),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );

  hs_slave #(.DW(DW), .HW(HW)) u_slave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .hold_i   (rcv_hold_i),
    .req_i    (req_w),
    .ready_i  (ready_i),
    .data_i   (bus_w),
    .ack_o    (ack_w),
    .rdata_o  (rdata_o),
    .rvalid_o (rdata_valid_o)
  );

  assign req_o = req_w;
  assign ack_o = ack_w;
endmodule

// File: tb/req_ack_handshake_tb.sv
module req_ack_handshake_tb;
  localparam int DW = 16;
  localparam int HW = 8;
  localparam int TO = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    mode = '0;
  logic [HW-1:0] mh = 8'd1, sh = 8'd1;
  logic          start = 1'b0, ready = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          req, ack, rvalid, done, tout;
  logic [DW-1:0] rdata;

  req_ack_handshake #(.DW(DW), .HW(HW), .TO_CYC(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .snd_hold_i(mh), .rcv_hold_i(sh),
    .start_i(start), .wdata_i(wdata), .ready_i(ready), .req_o(req), .ack_o(ack),
    .rdata_o(rdata), .rdata_valid_o(rvalid), .done_o(done), .timeout_o(tout)
  );

  int vecs = 0, errs = 0, cyc = 0;
  int req_hi, ack_hi, req_rise, ack_rise, done_n, done_bad, rv_n;
  logic p_req = 1'b0, p_ack = 1'b0;

  always @(negedge clk) begin
    if (req) req_hi++;
    if (ack) ack_hi++;
    if (req && !p_req) req_rise++;
    if (ack && !p_ack) ack_rise++;
    if (done) begin
      done_n++;
      if (req || !p_req) done_bad++;
    end
    if (rvalid) rv_n++;
    p_req = req;
    p_ack = ack;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_hi = 0; ack_hi = 0; req_rise = 0; ack_rise = 0;
    done_n = 0; done_bad = 0; rv_n = 0;
  endtask

  // d < 0: ready never rises; stray > 0: extra start pulse at that negedge
  task automatic run(input int m, input int hm, input int hs, input int d,
                     input int stray, input logic [DW-1:0] w);
    @(posedge clk); #1; clr();
    @(negedge clk);
    mode = 2'(m); mh = HW'(hm); sh = HW'(hs); wdata = w; start = 1'b1; ready = 1'b0;
    for (int i = 1; i < 5000; i++) begin
      @(negedge clk);
      start = (i == stray);
      ready = (d >= 0 && i >= 1 + d);
      if (i == 1) wdata = ~w;
      if (i > stray + 1 && req_rise > 0 && !req && !ack) break;
    end
    start = 1'b0; ready = 1'b0;
    repeat (2) @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    int hms[4] = '{1, 2, 3, 5};
    int hss[3] = '{1, 3, 4};
    int ds[3]  = '{0, 1, 3};
    logic [DW-1:0] w;
    int n = 0;

    repeat (3) @(negedge clk);
    // R1
    chk("R1 req", int'(req), 0);
    chk("R1 ack", int'(ack), 0);
    chk("R1 flags", int'({done, tout, rvalid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'({req, ack, done, tout}), 0);

    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 3; c++) begin
            int er, ea, eh;
            n++;
            w = DW'(16'hA5C3 ^ (n * 16'h1357));
            run(m, hms[a], hss[b], ds[c], 0, w);
            if (m == 0) begin
              er = hms[a];
              ea = (1 + ds[c] <= hms[a]) ? 1 : 0;
              eh = ea * hss[b];
              chk("R2 loose req high time", req_hi, er);
              chk("R3 loose ack high time", ack_hi, eh);
            end else begin
              er = 2 + ds[c];
              ea = 1;
              eh = (m == 1) ? hss[b] : 2;
              chk("R4 req falls after ack", req_hi, er);
              if (m == 1) chk("R3 half ack high time", ack_hi, eh);
              else        chk("R5 full ack falls after req", ack_hi, eh);
            end
            chk("R6 ack rises", ack_rise, ea);
            chk("R7 rvalid count", rv_n, ea);
            if (ea == 1) chk("R7 captured word", int'(rdata), int'(w));
            chk("R8 single request", req_rise, 1);
            chk("R9 done count", done_n, 1);
            chk("R9 done placement", done_bad, 0);
          end

    // R8: start during an active half-locked request
    run(1, 1, 1, 3, 2, 16'h1234);
    chk("R8 start mid request", req_rise, 1);
    chk("R4 req high with late ready", req_hi, 5);
    // R8: start while ack still high after loose request ended
    run(0, 1, 6, 0, 3, 16'h4321);
    chk("R8 start while ack high", req_rise, 1);
    chk("R3 ack outlives req", ack_hi, 6);
    chk("R7 word loose", int'(rdata), 16'h4321);

    // R10 watchdog, half-locked then fully locked
    run(1, 1, 1, -1, 0, 16'h0F0F);
    chk("R10 half req high time", req_hi, TO);
    chk("R10 half no done", done_n, 0);
    chk("R10 half flag", int'(tout), 1);
    chk("R6 no ack without ready", ack_rise, 0);
    run(2, 1, 1, -1, 0, 16'h0F0F);
    chk("R10 full req high time", req_hi, TO);
    chk("R10 full flag", int'(tout), 1);
    repeat (10) @(negedge clk);
    chk("R10 flag holds", int'(tout), 1);
    run(2, 1, 1, 0, 0, 16'hBEEF);
    chk("R10 flag cleared by start", int'(tout), 0);
    chk("R9 done after recovery", done_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule